// File: doc/BRIEF.md
# Byte-Tagged Data Memory with Register Tag File

This block holds the data words of a protected core together with a one-bit security tag for every byte. One read/write port moves a word's data and its four byte tags together in a single access. Byte enables select the lanes that a store changes, so byte, halfword and word stores need no separate modes. A second kind of store, the mark operation, sets the tags of the enabled bytes to 1 and leaves their data as it was. Software uses it to flag data that arrived over an untrusted channel.

A companion register file holds a 32-bit value and one tag bit for each general register. A register's value and its tag share the same register index. The file has one write port that can also mark a register as spurious, and two combinational read ports. Register 0 always reads as a zero value with a clear tag.

Top module: `tagged_store`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mem_rvalid`, `mem_rdata` and `mem_rtag` clear to 0, and every register clears to value 0 with tag 0.
- R2: A read (`mem_req`=1, `mem_we`=0, `mem_tagonly`=0) returns the addressed word on `mem_rdata` and its byte tags on `mem_rtag` at the next clock edge, with `mem_rvalid` high for exactly that one cycle. `mem_rvalid` is low after any cycle without a read.
- R3: A store (`mem_req`=1, `mem_we`=1, `mem_tagonly`=0) writes data byte i (`mem_wdata[8i+7:8i]`) and tag `mem_wtag[i]` only when `mem_be[i]` is 1. Bytes and tags of lanes with a clear enable keep their values.
- R4: A mark (`mem_req`=1, `mem_tagonly`=1, whatever `mem_we` is) sets the tag of every lane whose `mem_be` bit is 1 and leaves all data bytes unchanged. The tags of lanes with a clear enable also stay as they were.
- R5: In any cycle where `mem_rvalid` is low, `mem_rdata` and `mem_rtag` keep the values of the last read, or 0 if there has been no read since reset.
- R6: A register write (`rf_we`=1, `rf_waddr`≠0) stores `rf_wdata` and `rf_wtag`. From the next cycle, either read port addressed to that register returns them combinationally.
- R7: A register mark (`rf_mark`=1, `rf_we`=0, `rf_waddr`≠0) sets that register's tag to 1 and leaves its value unchanged.
- R8: Register 0 always reads as value 0 with tag 0 on both ports. Writes and marks aimed at it have no effect.
- R9: When `rf_we` and `rf_mark` are both 1 for a nonzero register, the value is written and the stored tag is 1, whatever `rf_wtag` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | Store when set, read when clear |
| mem_tagonly | input | 1 | Mark operation: set tags of enabled bytes only |
| mem_addr | input | AW (8) | Word index |
| mem_be | input | 4 | Byte enables, bit i selects bits 8i+7:8i |
| mem_wdata | input | 32 | Store data |
| mem_wtag | input | 4 | Store tags, one per byte |
| mem_rdata | output | 32 | Read data |
| mem_rtag | output | 4 | Read tags, one per byte |
| mem_rvalid | output | 1 | Read result valid |
| rf_we | input | 1 | Register write enable |
| rf_mark | input | 1 | Register tag-set enable |
| rf_waddr | input | RAW (5) | Register write index |
| rf_wdata | input | 32 | Register write value |
| rf_wtag | input | 1 | Register write tag |
| rf_raddr_a | input | RAW (5) | Read port A index |
| rf_rdata_a | output | 32 | Read port A value |
| rf_rtag_a | output | 1 | Read port A tag |
| rf_raddr_b | input | RAW (5) | Read port B index |
| rf_rdata_b | output | 32 | Read port B value |
| rf_rtag_b | output | 1 | Read port B tag |

## Verification
A memory read result appears one clock edge after the request, behind one register, and a store or mark becomes visible to a read issued in any later cycle. Register file writes and marks take effect at the edge that samples them, and the combinational read ports show the new contents in the half cycle that follows. The bench drives inputs on the falling edge, updates its behavioural model at the rising edge using those same inputs, and compares every output with the model at the next falling edge. Each result is therefore checked in the exact cycle it is due, and a result that arrives early or late is caught.

// File: rtl/tagmem_pkg.sv
// Shared definitions for the byte-tagged data memory.
// Assumes a 32-bit data path split into 8-bit lanes.
package tagmem_pkg;
    localparam int XLEN  = 32;
    localparam int LANES = XLEN / 8;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_READ,
        OP_STORE,
        OP_MARK
    } mem_op_e;

    // Decode the port controls into one operation; mark wins over store.
    function automatic mem_op_e decode_op(input logic req, input logic we, input logic tagonly);
        if (!req)         return OP_IDLE;
        else if (tagonly) return OP_MARK;
        else if (we)      return OP_STORE;
        else              return OP_READ;
    endfunction
endpackage

// File: rtl/tagmem_lane.sv
// One byte lane of the data memory: an 8-bit data array and a 1-bit tag
// array that share the same index. Assumes the lane controls are mutually
// exclusive. The array contents are not reset, only the read register is.
module tagmem_lane #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic          mark_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wbyte,
    input  logic          wtag,
    output logic [7:0]    rbyte,
    output logic          rtag
);
    logic [7:0] data_q [DEPTH];
    logic       tag_q  [DEPTH];

    // Array update: a store writes byte and tag, a mark sets only the tag.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[addr] <= wbyte;
            tag_q[addr]  <= wtag;
        end else if (mark_en) begin
            tag_q[addr]  <= 1'b1;
        end
    end

    // Read register: captures byte and tag together, holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbyte <= '0;
            rtag  <= 1'b0;
        end else if (rd_en) begin
            rbyte <= data_q[addr];
            rtag  <= tag_q[addr];
        end
    end
endmodule

// File: rtl/tagmem_bank.sv
// Word-wide data memory built from byte lanes. Decodes the operation once
// and gates each lane with its byte enable. The read returns all lanes in
// the cycle after the request, with a one-cycle valid pulse.
module tagmem_bank
    import tagmem_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic             tagonly,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] be,
    input  logic [XLEN-1:0]  wdata,
    input  logic [LANES-1:0] wtag,
    output logic [XLEN-1:0]  rdata,
    output logic [LANES-1:0] rtag,
    output logic             rvalid
);
    mem_op_e op;
    logic    do_read;

    // Operation decode for this cycle.
    always_comb begin
        op      = decode_op(req, we, tagonly);
        do_read = (op == OP_READ);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tagmem_lane #(.DEPTH(DEPTH)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (do_read),
            .wr_en   ((op == OP_STORE) && be[g]),
            .mark_en ((op == OP_MARK) && be[g]),
            .addr    (addr),
            .wbyte   (wdata[8*g +: 8]),
            .wtag    (wtag[g]),
            .rbyte   (rdata[8*g +: 8]),
            .rtag    (rtag[g])
        );
    end

    // Valid pulse, one cycle behind the read request.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= do_read;
    end
endmodule

// File: rtl/regtag_file.sv
// General register file with one tag bit per register, one write port that
// can also mark a register as spurious, and two combinational read ports.
// Assumes index 0 is the hard-wired zero register.
module regtag_file #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int RAW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             mark,
    input  logic [RAW-1:0]   waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             wtag,
    input  logic [RAW-1:0]   raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    output logic             rtag_a,
    input  logic [RAW-1:0]   raddr_b,
    output logic [WIDTH-1:0] rdata_b,
    output logic             rtag_b
);
    logic [WIDTH-1:0] val_q [NREG];
    logic             tag_q [NREG];
    logic             wr_ok;

    // Writes aimed at the zero register are dropped.
    always_comb wr_ok = (waddr != '0);

    // Register update: write stores value and tag, mark forces the tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                val_q[i] <= '0;
                tag_q[i] <= 1'b0;
            end
        end else if (wr_ok && we) begin
            val_q[waddr] <= wdata;
            tag_q[waddr] <= wtag | mark;
        end else if (wr_ok && mark) begin
            tag_q[waddr] <= 1'b1;
        end
    end

    // Read ports: the zero register reads as zero value and clear tag.
    always_comb begin
        rdata_a = (raddr_a == '0) ? '0   : val_q[raddr_a];
        rtag_a  = (raddr_a == '0) ? 1'b0 : tag_q[raddr_a];
        rdata_b = (raddr_b == '0) ? '0   : val_q[raddr_b];
        rtag_b  = (raddr_b == '0) ? 1'b0 : tag_q[raddr_b];
    end
endmodule

// File: rtl/tagged_store.sv
// Top of the byte-tagged storage: the tagged data memory and the tagged
// register file side by side. They share only the clock and reset.
module tagged_store
    import tagmem_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int NREG  = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int RAW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_req,
    input  logic             mem_we,
    input  logic             mem_tagonly,
    input  logic [AW-1:0]    mem_addr,
    input  logic [LANES-1:0] mem_be,
    input  logic [XLEN-1:0]  mem_wdata,
    input  logic [LANES-1:0] mem_wtag,
    output logic [XLEN-1:0]  mem_rdata,
    output logic [LANES-1:0] mem_rtag,
    output logic             mem_rvalid,
    input  logic             rf_we,
    input  logic             rf_mark,
    input  logic [RAW-1:0]   rf_waddr,
    input  logic [XLEN-1:0]  rf_wdata,
    input  logic             rf_wtag,
    input  logic [RAW-1:0]   rf_raddr_a,
    output logic [XLEN-1:0]  rf_rdata_a,
    output logic             rf_rtag_a,
    input  logic [RAW-1:0]   rf_raddr_b,
    output logic [XLEN-1:0]  rf_rdata_b,
    output logic             rf_rtag_b
);
    tagmem_bank #(.DEPTH(DEPTH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (mem_req),
        .we      (mem_we),
        .tagonly (mem_tagonly),
        .addr    (mem_addr),
        .be      (mem_be),
        .wdata   (mem_wdata),
        .wtag    (mem_wtag),
        .rdata   (mem_rdata),
        .rtag    (mem_rtag),
        .rvalid  (mem_rvalid)
    );

    regtag_file #(.NREG(NREG), .WIDTH(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .mark    (rf_mark),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .wtag    (rf_wtag),
        .raddr_a (rf_raddr_a),
        .rdata_a (rf_rdata_a),
        .rtag_a  (rf_rtag_a),
        .raddr_b (rf_raddr_b),
        .rdata_b (rf_rdata_b),
        .rtag_b  (rf_rtag_b)
    );
endmodule

// File: rtl/tagged_store_chk.sv
// Property checker for tagged_store, attached by bind. Observes ports only.
// The armed flag keeps past-value checks inside the cycles since reset.
module tagged_store_chk #(
    parameter int XLEN = 32,
    parameter int LANES = 4,
    parameter int RAW  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_tagonly,
    input logic [XLEN-1:0]  mem_rdata,
    input logic [LANES-1:0] mem_rtag,
    input logic             mem_rvalid,
    input logic             rf_we,
    input logic             rf_mark,
    input logic [RAW-1:0]   rf_waddr,
    input logic [XLEN-1:0]  rf_wdata,
    input logic             rf_wtag,
    input logic [RAW-1:0]   rf_raddr_a,
    input logic [XLEN-1:0]  rf_rdata_a,
    input logic             rf_rtag_a,
    input logic [RAW-1:0]   rf_raddr_b,
    input logic [XLEN-1:0]  rf_rdata_b,
    input logic             rf_rtag_b
);
    logic armed;

    // Becomes set one cycle after reset is released.
    always_ff @(posedge clk) armed <= rst_n;

    // R2
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !mem_tagonly) |=> mem_rvalid);

    // R2
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && !mem_we && !mem_tagonly) |=> !mem_rvalid);

    // R5
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !mem_rvalid |-> ($stable(mem_rdata) && $stable(mem_rtag)));

    // R8
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_raddr_a == '0) |-> (rf_rdata_a == '0 && !rf_rtag_a));

    // R8
    zero_reg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_raddr_b == '0) |-> (rf_rdata_b == '0 && !rf_rtag_b));

    // R6
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rf_we && rf_waddr != '0) && rf_raddr_a == $past(rf_waddr))
        |-> (rf_rdata_a == $past(rf_wdata) && rf_rtag_a == $past(rf_wtag || rf_mark)));

    // R7
    reg_mark_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rf_mark && !rf_we && rf_waddr != '0) && rf_raddr_b == $past(rf_waddr)
         && $past(rf_raddr_b) == $past(rf_waddr))
        |-> (rf_rtag_b && rf_rdata_b == $past(rf_rdata_b)));

    // R9
    reg_write_mark_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rf_mark && rf_we && rf_waddr != '0) && rf_raddr_b == $past(rf_waddr))
        |-> rf_rtag_b);
endmodule

bind tagged_store tagged_store_chk #(.XLEN(XLEN), .LANES(LANES), .RAW(RAW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_tagonly (mem_tagonly),
    .mem_rdata   (mem_rdata),
    .mem_rtag    (mem_rtag),
    .mem_rvalid  (mem_rvalid),
    .rf_we       (rf_we),
    .rf_mark     (rf_mark),
    .rf_waddr    (rf_waddr),
    .rf_wdata    (rf_wdata),
    .rf_wtag     (rf_wtag),
    .rf_raddr_a  (rf_raddr_a),
    .rf_rdata_a  (rf_rdata_a),
    .rf_rtag_a   (rf_rtag_a),
    .rf_raddr_b  (rf_raddr_b),
    .rf_rdata_b  (rf_rdata_b),
    .rf_rtag_b   (rf_rtag_b)
);

// File: tb/sim_tagged_store.sv
`timescale 1ns/100ps
// Bench for tagged_store: behavioural model updated at each rising edge,
// outputs compared at every falling edge.
module sim_tagged_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req = 0, mem_we = 0, mem_tagonly = 0;
    logic [7:0]  mem_addr = '0;
    logic [3:0]  mem_be = '0, mem_wtag = '0;
    logic [31:0] mem_wdata = '0;
    logic [31:0] mem_rdata;
    logic [3:0]  mem_rtag;
    logic        mem_rvalid;
    logic        rf_we = 0, rf_mark = 0, rf_wtag = 0;
    logic [4:0]  rf_waddr = '0, rf_raddr_a = '0, rf_raddr_b = '0;
    logic [31:0] rf_wdata = '0;
    logic [31:0] rf_rdata_a, rf_rdata_b;
    logic        rf_rtag_a, rf_rtag_b;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Reference model state
    logic [7:0]  ref_md [int];
    logic        ref_mt [int];
    logic [31:0] ref_rv [32];
    logic        ref_rt [32];
    logic        exp_valid;
    logic [31:0] exp_rdata;
    logic [3:0]  exp_rtag;

    always #2.5 clk = ~clk;

    tagged_store u0 (.*);

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            exp_valid = 0; exp_rdata = '0; exp_rtag = '0;
            for (int i = 0; i < 32; i++) begin ref_rv[i] = '0; ref_rt[i] = 0; end
            return;
        end
        exp_valid = mem_req && !mem_we && !mem_tagonly;
        if (exp_valid) begin
            for (int i = 0; i < 4; i++) begin
                exp_rdata[8*i +: 8] = ref_md[mem_addr*4+i];
                exp_rtag[i]         = ref_mt[mem_addr*4+i];
            end
        end else if (mem_req) begin
            for (int i = 0; i < 4; i++) begin
                if (mem_be[i] && mem_tagonly) ref_mt[mem_addr*4+i] = 1'b1;
                else if (mem_be[i]) begin
                    ref_md[mem_addr*4+i] = mem_wdata[8*i +: 8];
                    ref_mt[mem_addr*4+i] = mem_wtag[i];
                end
            end
        end
        if (rf_waddr != 0) begin
            if (rf_we) begin
                ref_rv[rf_waddr] = rf_wdata;
                ref_rt[rf_waddr] = rf_wtag | rf_mark;
            end else if (rf_mark) ref_rt[rf_waddr] = 1'b1;
        end
    endtask

    task automatic compare();
        chk("mem_rvalid", 64'(mem_rvalid), 64'(exp_valid));
        chk("mem_rdata",  64'(mem_rdata),  64'(exp_rdata));
        chk("mem_rtag",   64'(mem_rtag),   64'(exp_rtag));
        chk("rf_rdata_a", 64'(rf_rdata_a), 64'(ref_rv[rf_raddr_a]));
        chk("rf_rtag_a",  64'(rf_rtag_a),  64'(ref_rt[rf_raddr_a]));
        chk("rf_rdata_b", 64'(rf_rdata_b), 64'(ref_rv[rf_raddr_b]));
        chk("rf_rtag_b",  64'(rf_rtag_b),  64'(ref_rt[rf_raddr_b]));
    endtask

    // One cycle: model at the rising edge, compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst_n) compare();
        mem_req = 0; mem_we = 0; mem_tagonly = 0;
        rf_we = 0; rf_mark = 0;
    endtask

    task automatic mem_op(logic we, logic tonly, logic [7:0] a, logic [3:0] be,
                          logic [31:0] d, logic [3:0] t);
        mem_req = 1; mem_we = we; mem_tagonly = tonly; mem_addr = a;
        mem_be = be; mem_wdata = d; mem_wtag = t;
        tick();
    endtask

    task automatic rd(logic [7:0] a);
        mem_op(0, 0, a, 4'h0, 32'h0, 4'h0);
    endtask

    task automatic rf_op(logic we, logic mk, logic [4:0] a, logic [31:0] d, logic t);
        rf_we = we; rf_mark = mk; rf_waddr = a; rf_wdata = d; rf_wtag = t;
        tick();
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1;
        // R1: reset state of outputs and registers
        cur_req = "R1";
        for (int r = 0; r < 32; r += 2) begin rf_raddr_a = 5'(r); rf_raddr_b = 5'(r+1); tick(); end

        // R3: full-word stores then reads at several addresses
        cur_req = "R3";
        for (int a = 0; a < 8; a++) mem_op(1, 0, 8'(a*9), 4'hF, 32'hA1B2C3D4 ^ (a * 32'h01010101), 4'(a));
        mem_op(1, 0, 8'd255, 4'hF, 32'hDEADBEEF, 4'b1010);
        for (int a = 0; a < 8; a++) rd(8'(a*9));
        rd(8'd255);
        // R3: halfword and byte stores keep the other lanes
        mem_op(1, 0, 8'd9, 4'b0011, 32'h11112222, 4'b1111); rd(8'd9);
        mem_op(1, 0, 8'd18, 4'b0100, 32'h33445566, 4'b0100); rd(8'd18);
        mem_op(1, 0, 8'd27, 4'b0000, 32'hFFFFFFFF, 4'b1111); rd(8'd27);

        // R4: mark sets tags only, with and without the write flag
        cur_req = "R4";
        mem_op(0, 1, 8'd0, 4'b1100, 32'h0BADF00D, 4'b0000); rd(8'd0);
        mem_op(1, 1, 8'd36, 4'b0001, 32'h0BADF00D, 4'b0000); rd(8'd36);
        mem_op(1, 1, 8'd45, 4'b1111, 32'h0, 4'b0000); rd(8'd45);

        // R2: back-to-back reads
        cur_req = "R2";
        rd(8'd54); rd(8'd63); rd(8'd255); rd(8'd9);

        // R5: result holds through idle and store cycles
        cur_req = "R5";
        tick(); tick();
        mem_op(1, 0, 8'd9, 4'hF, 32'h12345678, 4'hF);
        mem_op(0, 1, 8'd9, 4'hF, 32'h0, 4'h0);
        tick(); rd(8'd9); tick();

        // R6: write every register, read both ports
        cur_req = "R6";
        for (int r = 1; r < 32; r++) rf_op(1, 0, 5'(r), 32'h5A000000 + 32'(r) * 32'h00010203, 1'(r));
        for (int r = 0; r < 32; r++) begin rf_raddr_a = 5'(r); rf_raddr_b = 5'(31-r); tick(); end

        // R7: mark leaves value
        cur_req = "R7";
        rf_raddr_b = 5'd4;
        rf_op(0, 1, 5'd4, 32'hFFFFFFFF, 1'b0);
        rf_raddr_a = 5'd6;
        rf_op(0, 1, 5'd6, 32'h0, 1'b0);

        // R9: write combined with mark stores a set tag
        cur_req = "R9";
        rf_raddr_b = 5'd8;
        rf_op(1, 1, 5'd8, 32'hCAFE0008, 1'b0);
        tick();

        // R8: register 0 ignores writes and marks
        cur_req = "R8";
        rf_raddr_a = 5'd0; rf_raddr_b = 5'd0;
        rf_op(1, 0, 5'd0, 32'hFFFFFFFF, 1'b1);
        rf_op(0, 1, 5'd0, 32'h0, 1'b0);
        rf_op(1, 1, 5'd0, 32'h77777777, 1'b1);
        tick();

        // R1: a second reset clears everything again
        cur_req = "R1";
        rst_n = 0; tick(); tick(); rst_n = 1;
        rf_raddr_a = 5'd8; rf_raddr_b = 5'd31; tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule